// File: doc/BRIEF.md
# High-Voltage Programmable Byte Memory Mode Model

This block is a synthesizable behavioural model of the control logic of a byte-wide, electrically erasable, one-time-style programmable read-only memory. It is meant for testbenches and emulation platforms that must stand in for such a part. The model receives three active-low strobes: chip select, output enable and write pulse. It also receives two single-bit flags that stand for analog levels. One flag marks the programming supply as raised. The other marks the high-voltage identification level on the address line used for that purpose. From these inputs the block selects one operating mode. That mode sets whether the data bus is driven, what value it carries, and whether the stored array changes.

Writes follow the rules of floating-gate cells. A program pulse can only clear bits, so the stored byte becomes the old byte ANDed with the input. A whole-array erase sets every byte to 0xFF. A write pulse counts only if its conditions were held for its whole length and it lasted at least a parameter-set number of clock cycles. A pulse that fails either test is discarded and a one-cycle error flag is raised.

The output-enable access delay and the output float delay are modelled as clock-cycle counts. The tri-state bus is split into a data output and a drive-enable output, and the surrounding pad logic resolves it. The default array is 1024 bytes. The address width parameter reaches the full 17-bit, 128K-byte organisation.

Top module: `hv_eprom_model`

## Requirements
- R1: After reset every byte reads 0xFF, `data_drive` is low and `pulse_err` is low.
- R2: While `chip_sel_n` is high, `op_mode` is STANDBY (code 0) with `prog_hv` low or INHIBIT (code 6) with `prog_hv` high, `data_drive` is low in the same cycle, and write pulses leave the array unchanged.
- R3: With `chip_sel_n` low, `out_en_n` low and both flags low, `op_mode` is READ (code 1) and the stored byte at `addr` is driven. With `out_en_n` high and no qualifying write pulse, `op_mode` is OUTPUT-OFF (code 2), and a write pulse with `prog_hv` low has no effect and raises no error.
- R4: With `chip_sel_n` low, `out_en_n` high, `prog_hv` high, `id_hv` low and `wr_pulse_n` low, `op_mode` is PROGRAM (code 3). An accepted pulse sets the byte at `addr` to its old value ANDed with `data_in`, so no bit ever goes from 0 to 1.
- R5: With the PROGRAM conditions but `id_hv` high and `addr` equal to zero, `op_mode` is ERASE (code 5), and an accepted pulse sets every byte to 0xFF. With `id_hv` high and `addr` nonzero, `op_mode` is INHIBIT (code 6) and nothing changes.
- R6: With `chip_sel_n` low, `out_en_n` low, `id_hv` high and `prog_hv` low, `op_mode` is ID-READ (code 7). The driven value is `MAKER_ID` (default 0xDA) when `addr[0]` is 0 and `PART_ID` (default 0x01) when `addr[0]` is 1.
- R7: With `chip_sel_n` low, `out_en_n` low and `prog_hv` high, `op_mode` is VERIFY (code 4) and the stored byte is driven, whatever the level of `id_hv`.
- R8: `data_drive` rises at the `OE_DLY`-th rising clock edge that samples a read-type mode (READ, VERIFY, ID-READ). After the read-type mode ends, it stays high through `FLOAT_DLY`-1 edges and falls at the `FLOAT_DLY`-th edge.
- R9: A pulse takes effect at the first rising edge that samples `wr_pulse_n` high again. It takes effect only if at least `MIN_PULSE` edges sampled it low, and only if the mode, `addr` and `data_in` kept their starting values at every one of those edges.
- R10: A tracked pulse that is too short or disturbed raises `pulse_err` for exactly one cycle, right after the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all delays count its rising edges |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_pulse_n | input | 1 | Active-low program/erase strobe |
| prog_hv | input | 1 | Programming supply raised flag |
| id_hv | input | 1 | High-voltage level present on the identification address line |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Data presented to the part for programming |
| data_out | output | 8 | Value the part places on the bus |
| data_drive | output | 1 | Bus drive enable; low means high impedance |
| op_mode | output | 3 | Decoded operating mode code |
| pulse_err | output | 1 | One-cycle flag for a discarded write pulse |

## Verification
The embedded properties check, on every cycle, that a program commit only clears bits of the addressed byte and that an erase commit fills the array. They also check that a commit happens only on a release edge after a full-width pulse, that the error flag never lasts two cycles, and that the bus drive only starts after a read-type request. Other behaviour can only be shown by the bench's scenarios: the mode code for each strobe and flag combination, the exact cycle counts of the access and float delays, the identification bytes, and the proof that inhibited, short or disturbed pulses leave the stored bytes untouched. For those scenarios the bench reads the stored bytes back through the normal read path.

// File: rtl/hv_eprom_pkg.sv
package hv_eprom_pkg;

   typedef enum logic [2:0] {
      M_STANDBY = 3'd0,
      M_READ    = 3'd1,
      M_OUT_OFF = 3'd2,
      M_PROGRAM = 3'd3,
      M_VERIFY  = 3'd4,
      M_ERASE   = 3'd5,
      M_INHIBIT = 3'd6,
      M_ID      = 3'd7
   } op_mode_e;

   localparam int unsigned BYTE_W = 8;

   function automatic logic is_read_mode(input op_mode_e m);
      return (m == M_READ) || (m == M_VERIFY) || (m == M_ID);
   endfunction

   function automatic logic is_write_mode(input op_mode_e m);
      return (m == M_PROGRAM) || (m == M_ERASE);
   endfunction

endpackage

// File: rtl/hv_eprom_mode_dec.sv
module hv_eprom_mode_dec
   import hv_eprom_pkg::*;
#(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              chip_sel_n,
   input  logic              out_en_n,
   input  logic              wr_pulse_n,
   input  logic              prog_hv,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   output op_mode_e          mode,
   output logic              rd_req
);

   always_comb begin
      mode = M_STANDBY;
      if (chip_sel_n) begin
         mode = prog_hv ? M_INHIBIT : M_STANDBY;
      end else if (!out_en_n) begin
         if (prog_hv)    mode = M_VERIFY;
         else if (id_hv) mode = M_ID;
         else            mode = M_READ;
      end else if (prog_hv && !wr_pulse_n) begin
         if (!id_hv)             mode = M_PROGRAM;
         else if (addr == '0)    mode = M_ERASE;
         else                    mode = M_INHIBIT;
      end else begin
         mode = M_OUT_OFF;
      end
   end

   assign rd_req = is_read_mode(mode);

endmodule

// File: rtl/hv_eprom_pulse_trk.sv
module hv_eprom_pulse_trk
   import hv_eprom_pkg::*;
#(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned MIN_PULSE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_mode_e          mode,
   input  logic              wr_pulse_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] data_in,
   output logic              prog_we,
   output logic              erase_we,
   output logic [ADDR_W-1:0] we_addr,
   output logic [BYTE_W-1:0] we_data,
   output logic              pulse_err
);

   localparam int unsigned CNT_W = $clog2(MIN_PULSE + 1);
   localparam logic [CNT_W-1:0] WIDTH_MIN = CNT_W'(MIN_PULSE);

   logic              active_q;
   logic              broken_q;
   op_mode_e          kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] data_q;
   logic [CNT_W-1:0]  width_q;
   logic              err_q;

   logic release_now;
   logic pulse_good;

   assign release_now = active_q && wr_pulse_n;
   assign pulse_good  = !broken_q && (width_q >= WIDTH_MIN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         broken_q <= 1'b0;
         kind_q   <= M_STANDBY;
         addr_q   <= '0;
         data_q   <= '0;
         width_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (!active_q) begin
            if (is_write_mode(mode)) begin
               active_q <= 1'b1;
               broken_q <= 1'b0;
               kind_q   <= mode;
               addr_q   <= addr;
               data_q   <= data_in;
               width_q  <= CNT_W'(1);
            end
         end else if (!wr_pulse_n) begin
            if ((mode != kind_q) || (addr != addr_q) || (data_in != data_q))
               broken_q <= 1'b1;
            if (width_q < WIDTH_MIN)
               width_q <= width_q + 1'b1;
         end else begin
            active_q <= 1'b0;
            err_q    <= !pulse_good;
         end
      end
   end

   assign prog_we   = release_now && pulse_good && (kind_q == M_PROGRAM);
   assign erase_we  = release_now && pulse_good && (kind_q == M_ERASE);
   assign we_addr   = addr_q;
   assign we_data   = data_q;
   assign pulse_err = err_q;

   // R9: a commit only on the edge that releases a full-width pulse
   p_commit_on_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_we || erase_we) |-> (wr_pulse_n && $past(!wr_pulse_n) && width_q >= WIDTH_MIN));

   // R10: the error flag is a single-cycle pulse
   p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_err |=> !pulse_err);

endmodule

// File: rtl/hv_eprom_array.sv
module hv_eprom_array
   import hv_eprom_pkg::*;
#(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_we,
   input  logic              erase_we,
   input  logic [ADDR_W-1:0] we_addr,
   input  logic [BYTE_W-1:0] we_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [BYTE_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n || erase_we) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      end else if (prog_we) begin
         mem_q[we_addr] <= mem_q[we_addr] & we_data;
      end
   end

   assign rd_data = mem_q[rd_addr];

   // R4: a program commit leaves old AND new in the addressed byte
   p_prog_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
      prog_we |=> (mem_q[$past(we_addr)] == ($past(mem_q[we_addr]) & $past(we_data))));

   // R5: an erase commit fills both ends of the array with ones
   p_erase_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      erase_we |=> ((mem_q[0] == 8'hFF) && (mem_q[DEPTH-1] == 8'hFF)));

endmodule

// File: rtl/hv_eprom_out_timer.sv
module hv_eprom_out_timer
   import hv_eprom_pkg::*;
#(
   parameter int unsigned OE_DLY    = 3,
   parameter int unsigned FLOAT_DLY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              chip_sel_n,
   input  logic [BYTE_W-1:0] rd_value,
   output logic [BYTE_W-1:0] data_out,
   output logic              data_drive
);

   localparam int unsigned ON_W  = $clog2(OE_DLY + 1);
   localparam int unsigned OFF_W = $clog2(FLOAT_DLY + 1);
   localparam logic [ON_W-1:0]  ON_LAST  = ON_W'(OE_DLY - 1);
   localparam logic [ON_W-1:0]  ON_TOP   = ON_W'(OE_DLY);
   localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(FLOAT_DLY - 1);

   logic [ON_W-1:0]   on_q;
   logic [OFF_W-1:0]  off_q;
   logic              drv_q;
   logic [BYTE_W-1:0] dq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_q  <= '0;
         off_q <= '0;
         drv_q <= 1'b0;
         dq_q  <= '0;
      end else if (rd_req) begin
         off_q <= '0;
         dq_q  <= rd_value;
         if (on_q != ON_TOP) on_q <= on_q + 1'b1;
         if (on_q >= ON_LAST) drv_q <= 1'b1;
      end else begin
         on_q <= '0;
         if (drv_q) begin
            if (off_q >= OFF_LAST) begin
               drv_q <= 1'b0;
               off_q <= '0;
            end else begin
               off_q <= off_q + 1'b1;
            end
         end
      end
   end

   assign data_out   = dq_q;
   assign data_drive = drv_q && !chip_sel_n;

   // R8: the drive only switches on after a read-type request was sampled
   p_drive_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_q) |-> $past(rd_req));

   // R8: a held request never lets the drive fall
   p_drive_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_q && rd_req) |=> drv_q);

endmodule

// File: rtl/hv_eprom_model.sv
module hv_eprom_model
   import hv_eprom_pkg::*;
#(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned OE_DLY    = 3,
   parameter int unsigned FLOAT_DLY = 2,
   parameter int unsigned MIN_PULSE = 4,
   parameter logic [7:0]  MAKER_ID  = 8'hDA,
   parameter logic [7:0]  PART_ID   = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_sel_n,
   input  logic              out_en_n,
   input  logic              wr_pulse_n,
   input  logic              prog_hv,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data_in,
   output logic [7:0]        data_out,
   output logic              data_drive,
   output logic [2:0]        op_mode,
   output logic              pulse_err
);

   if (ADDR_W < 1 || ADDR_W > 17) begin : g_bad_addr_w
      $error("ADDR_W must lie in 1..17");
   end
   if (OE_DLY < 1) begin : g_bad_oe_dly
      $error("OE_DLY must be at least 1");
   end
   if (FLOAT_DLY < 1) begin : g_bad_float_dly
      $error("FLOAT_DLY must be at least 1");
   end
   if (MIN_PULSE < 1) begin : g_bad_min_pulse
      $error("MIN_PULSE must be at least 1");
   end

   op_mode_e          mode;
   logic              rd_req;
   logic              prog_we;
   logic              erase_we;
   logic [ADDR_W-1:0] we_addr;
   logic [BYTE_W-1:0] we_data;
   logic [BYTE_W-1:0] arr_data;
   logic [BYTE_W-1:0] rd_value;

   hv_eprom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
      .chip_sel_n (chip_sel_n),
      .out_en_n   (out_en_n),
      .wr_pulse_n (wr_pulse_n),
      .prog_hv    (prog_hv),
      .id_hv      (id_hv),
      .addr       (addr),
      .mode       (mode),
      .rd_req     (rd_req)
   );

   hv_eprom_pulse_trk #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .wr_pulse_n (wr_pulse_n),
      .addr       (addr),
      .data_in    (data_in),
      .prog_we    (prog_we),
      .erase_we   (erase_we),
      .we_addr    (we_addr),
      .we_data    (we_data),
      .pulse_err  (pulse_err)
   );

   hv_eprom_array #(.ADDR_W(ADDR_W)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_we  (prog_we),
      .erase_we (erase_we),
      .we_addr  (we_addr),
      .we_data  (we_data),
      .rd_addr  (addr),
      .rd_data  (arr_data)
   );

   assign rd_value = (mode == M_ID) ? (addr[0] ? PART_ID : MAKER_ID) : arr_data;

   hv_eprom_out_timer #(.OE_DLY(OE_DLY), .FLOAT_DLY(FLOAT_DLY)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req     (rd_req),
      .chip_sel_n (chip_sel_n),
      .rd_value   (rd_value),
      .data_out   (data_out),
      .data_drive (data_drive)
   );

   assign op_mode = mode;

endmodule

// File: tb/hv_eprom_model_bench.sv
module hv_eprom_model_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 10;
   localparam int DEP  = 1 << AW;
   localparam int OE   = 3;
   localparam int FL   = 2;
   localparam int MP   = 4;
   localparam logic [7:0] MID = 8'hDA;
   localparam logic [7:0] PID = 8'h01;

   localparam logic [2:0] C_STANDBY = 3'd0, C_READ = 3'd1, C_OFF = 3'd2, C_PROG = 3'd3,
                          C_VERIFY = 3'd4, C_ERASE = 3'd5, C_INHIBIT = 3'd6, C_ID = 3'd7;

   logic clk = 1'b0;
   logic rst_n;
   logic chip_sel_n, out_en_n, wr_pulse_n, prog_hv, id_hv;
   logic [AW-1:0] addr;
   logic [7:0] data_in, data_out;
   logic data_drive, pulse_err;
   logic [2:0] op_mode;

   int n_chk  = 0;
   int n_fail = 0;
   logic [7:0] ref_mem [DEP];

   always #(CLK_PERIOD/2) clk = ~clk;

   hv_eprom_model #(.ADDR_W(AW), .OE_DLY(OE), .FLOAT_DLY(FL), .MIN_PULSE(MP),
                    .MAKER_ID(MID), .PART_ID(PID)) u_hv_eprom_model (
      .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
      .wr_pulse_n(wr_pulse_n), .prog_hv(prog_hv), .id_hv(id_hv), .addr(addr),
      .data_in(data_in), .data_out(data_out), .data_drive(data_drive),
      .op_mode(op_mode), .pulse_err(pulse_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      chip_sel_n = 1'b1; out_en_n = 1'b1; wr_pulse_n = 1'b1;
      prog_hv = 1'b0; id_hv = 1'b0;
   endtask

   function automatic logic [2:0] read_mode(input logic vpp, input logic hv);
      if (vpp) return C_VERIFY;
      if (hv)  return C_ID;
      return C_READ;
   endfunction

   function automatic logic [7:0] read_value(input logic [AW-1:0] a, input logic vpp, input logic hv);
      if (!vpp && hv) return a[0] ? PID : MID;
      return ref_mem[a];
   endfunction

   function automatic logic [2:0] pulse_mode(input logic [AW-1:0] a, input logic vpp, input logic hv);
      if (!vpp) return C_OFF;
      if (!hv)  return C_PROG;
      return (a == '0) ? C_ERASE : C_INHIBIT;
   endfunction

   // full read cycle: mode, access delay, value, float delay (R3 R6 R7 R8)
   task automatic rd(input logic [AW-1:0] a, input logic vpp, input logic hv, input string tag);
      logic [7:0] ev;
      ev = read_value(a, vpp, hv);
      chip_sel_n = 1'b0; out_en_n = 1'b0; wr_pulse_n = 1'b1;
      prog_hv = vpp; id_hv = hv; addr = a;
      #1 chk({tag, " mode"}, 32'(op_mode), 32'(read_mode(vpp, hv)));
      for (int k = 1; k < OE; k++) begin
         tick();
         chk("R8 drive before access delay", 32'(data_drive), 32'd0);
      end
      tick();
      chk("R8 drive at access delay", 32'(data_drive), 32'd1);
      chk({tag, " data"}, 32'(data_out), 32'(ev));
      out_en_n = 1'b1;
      #1 chk("R3 output-off mode", 32'(op_mode), 32'(C_OFF));
      for (int k = 1; k < FL; k++) begin
         tick();
         chk("R8 drive held in float window", 32'(data_drive), 32'd1);
      end
      tick();
      chk("R8 drive off after float delay", 32'(data_drive), 32'd0);
      idle();
      tick();
   endtask

   // write pulse of len low edges; disturb changes data after the first edge (R4 R5 R9 R10)
   task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d, input logic vpp,
                        input logic hv, input int len, input logic disturb);
      logic tracked, good;
      tracked = vpp && (!hv || a == '0);
      good    = tracked && !disturb && (len >= MP);
      chip_sel_n = 1'b0; out_en_n = 1'b1; prog_hv = vpp; id_hv = hv;
      addr = a; data_in = d; wr_pulse_n = 1'b0;
      #1 chk("R4 R5 write mode", 32'(op_mode), 32'(pulse_mode(a, vpp, hv)));
      for (int k = 1; k <= len; k++) begin
         tick();
         if (disturb && k == 1) data_in = ~d;
      end
      wr_pulse_n = 1'b1;
      tick();
      chk("R10 error after release", 32'(pulse_err), 32'(tracked && !good));
      tick();
      chk("R10 error lasts one cycle", 32'(pulse_err), 32'd0);
      if (good) begin
         if (hv) for (int i = 0; i < DEP; i++) ref_mem[i] = 8'hFF;
         else    ref_mem[a] = ref_mem[a] & d;
      end
      idle();
      tick();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h1d5e_ed01));
      for (int i = 0; i < DEP; i++) ref_mem[i] = 8'hFF;
      idle();
      addr = '0; data_in = '0; rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      chk("R1 reset drive", 32'(data_drive), 32'd0);
      chk("R1 reset error", 32'(pulse_err), 32'd0);
      chk("R2 standby mode", 32'(op_mode), 32'(C_STANDBY));
      rd(0, 1'b0, 1'b0, "R1 erased after reset");
      rd(DEP - 1, 1'b0, 1'b0, "R1 erased top byte");

      // R4 program and AND behaviour
      pulse(5, 8'hA5, 1'b1, 1'b0, MP, 1'b0);
      rd(5, 1'b0, 1'b0, "R4 programmed byte");
      pulse(5, 8'h0F, 1'b1, 1'b0, MP + 2, 1'b0);
      rd(5, 1'b0, 1'b0, "R4 second program ANDs");
      pulse(5, 8'hFF, 1'b1, 1'b0, MP, 1'b0);
      rd(5, 1'b0, 1'b0, "R4 bits never rise");

      // R9 short and disturbed pulses
      pulse(6, 8'h00, 1'b1, 1'b0, MP - 1, 1'b0);
      rd(6, 1'b0, 1'b0, "R9 short pulse ignored");
      pulse(7, 8'h3C, 1'b1, 1'b0, MP + 1, 1'b1);
      rd(7, 1'b0, 1'b0, "R9 disturbed pulse ignored");

      // R3 pulse without programming supply
      pulse(8, 8'h00, 1'b0, 1'b0, MP + 1, 1'b0);
      rd(8, 1'b0, 1'b0, "R3 pulse without supply ignored");

      // R2 pulse while deselected
      chip_sel_n = 1'b1; out_en_n = 1'b1; prog_hv = 1'b1; addr = 9; data_in = 8'h00;
      wr_pulse_n = 1'b0;
      #1 chk("R2 inhibit mode", 32'(op_mode), 32'(C_INHIBIT));
      repeat (MP + 1) tick();
      wr_pulse_n = 1'b1;
      tick();
      chk("R2 no error when deselected", 32'(pulse_err), 32'd0);
      idle();
      tick();
      rd(9, 1'b0, 1'b0, "R2 deselected pulse ignored");

      // R2 deselect floats at once
      chip_sel_n = 1'b0; out_en_n = 1'b0; addr = 5;
      repeat (OE) tick();
      chk("R8 driving before deselect", 32'(data_drive), 32'd1);
      chip_sel_n = 1'b1;
      #1 chk("R2 deselect floats at once", 32'(data_drive), 32'd0);
      idle();
      repeat (FL + 1) tick();

      // R6 identification bytes, R7 verify
      rd(0, 1'b0, 1'b1, "R6 maker id");
      rd(1, 1'b0, 1'b1, "R6 part id");
      rd(2, 1'b0, 1'b1, "R6 maker id on even address");
      rd(5, 1'b1, 1'b0, "R7 verify data");
      rd(5, 1'b1, 1'b1, "R7 verify with id level");

      // R5 inhibited and real erase
      pulse(3, 8'hFF, 1'b1, 1'b1, MP + 1, 1'b0);
      rd(5, 1'b0, 1'b0, "R5 inhibit keeps data");
      pulse(0, 8'hFF, 1'b1, 1'b1, MP, 1'b0);
      rd(5, 1'b0, 1'b0, "R5 erase restores ones");
      rd(DEP - 1, 1'b0, 1'b0, "R5 erase reaches top");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [AW-1:0] a;
         op = int'($urandom_range(0, 9));
         a  = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 15));
         case (op)
            0, 1, 2, 3: rd(a, 1'($urandom), 1'b0, "R3 R7 random read");
            4, 5, 6: begin
               int len;
               len = int'($urandom_range(1, MP + 2));
               pulse(a, 8'($urandom), 1'($urandom_range(0, 5) != 0), 1'b0, len,
                     (len >= 2) && ($urandom_range(0, 7) == 0));
            end
            7: rd(a, 1'b0, 1'b1, "R6 random id read");
            8: begin
               if ($urandom_range(0, 3) == 0) pulse(0, 8'hFF, 1'b1, 1'b1, MP, 1'b0);
               else                           pulse(a | 1, 8'h00, 1'b1, 1'b1, MP, 1'b0);
            end
            default: repeat (2) tick();
         endcase
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule